// File: doc/BRIEF.md
# MDIO Management Frame Engine with Status Polling

This block drives the two-wire management interface of Ethernet PHYs. It owns two physical ports, each with a management clock, a data output, a data output enable and a data input. A configuration bit chooses which port is active. The host reaches the block through a small register file. Each write and each read takes one cycle, and a read returns its data combinationally.

The block has three modes:

- **Frame mode.** The host writes a 32-bit frame word. The engine sends a run of ones as a preamble, then the frame, most significant bit first. On a read opcode it releases the line for the turnaround and captures 16 data bits. It then sets a completion bit in the frame register.
- **Poll mode.** The engine repeatedly reads one configured PHY register, with an idle gap between reads. It keeps the last value read and accumulates the bits that changed since the previous read. It raises an interrupt level when a changed bit is not masked.
- **Bit-bang mode.** Three single-bit host registers drive the clock, data and enable of the selected port directly.

The interface has no handshake. The frame register takes a new word only when the engine is idle and neither bit-bang nor polling is enabled; any other write to it is dropped. Software learns that a frame has finished by reading the completion bit.

Register map (3-bit address):

| Address | Contents |
|---|---|
| 0 | Configuration |
| 1 | Frame |
| 2 | Poll status |
| 3 | Poll mask |
| 4 | Bit-bang clock |
| 5 | Bit-bang data |
| 6 | Bit-bang enable |

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset:
  - configuration, frame and poll status registers read 0;
  - the poll mask reads 0x0000FFFF;
  - `irq` is 0;
  - every clock, data-enable and data-output pin is 0.
- R2: Every frame is preceded by PREAMBLE_LEN (default 32) consecutive driven one bits. The data output and enable change only on the cycle the management clock falls.
- R3: A frame word has this layout: bits 31:30 start pattern (01), 29:28 opcode (10 read, 01 write), 27:23 PHY address, 22:18 register address, 17:16 turnaround, 15:0 data. Bits 31:18 are sent as written. On a write opcode the engine then sends turnaround 10 and the 16 data bits, most significant bit first.
- R4: Read frames and the completion bit:
  - On a read opcode the engine releases the line (enable 0) for both turnaround bits and the 16 data bits.
  - The data bits, sampled as the clock rises, land in frame register bits 15:0.
  - Bit 16 of the frame register reads 0 while a host frame runs and 1 once it has finished.
- R5: A write to the frame register while a frame is running is dropped: the frame register and the line keep the running frame.
- R6: Configuration bit 0 selects the port. It is latched when a frame starts. The unselected port's clock and enable stay 0.
- R7: The management clock runs only during a frame, with a period of 2*CLK_DIV system clocks.
- R8: Configuration bit 2 enables bit-bang mode:
  - the selected port's clock, data and enable follow register bits 4, 5 and 6 (bit 0 of each);
  - the other port stays idle;
  - frame writes are dropped.
- R9: Configuration bit 1 (while bit 2 is 0) starts polling:
  - each poll is a read of the PHY in config bits 14:10 and the register in config bits 7:3;
  - polls are separated by POLL_GAP idle cycles;
  - poll status bits 31:16 hold the last value read;
  - the first poll after enabling records no changes;
  - clearing the bit stops further polls.
- R10: Each later poll ORs the XOR of the old and new values into poll status bits 15:0. `irq` is high while any change bit is set whose poll mask bit is 0 (mask bit 1 blocks that bit).
- R11: A read of poll status with `rd_en` high clears the change bits, so `irq` drops until a new change arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; side effect on poll status only |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Unmasked poll change pending |
| mdc | output | 2 | Management clock per port |
| mdio_out | output | 2 | Management data output per port |
| mdio_oe | output | 2 | Management data output enable per port |
| mdio_in | input | 2 | Management data input per port |

## Verification
Assertions check these every cycle:
- the management clock holds between divider ticks;
- line data changes only at a falling clock;
- the line enable drops only during read frames;
- frame register writes during a running frame leave it untouched;
- the unselected port stays quiet in bit-bang mode;
- reading poll status empties the change bits.

Only the bench's scenarios can show the rest:
- that the right bits reach a modelled PHY in the right order;
- that read data is captured from the turnaround onward;
- the preamble length and the clock period;
- that polls target the configured address and stop when disabled;
- that masked and unmasked changes gate `irq`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;

  localparam logic [2:0] ADR_CFG   = 3'd0;
  localparam logic [2:0] ADR_FRAME = 3'd1;
  localparam logic [2:0] ADR_PSTAT = 3'd2;
  localparam logic [2:0] ADR_PMASK = 3'd3;
  localparam logic [2:0] ADR_BBCLK = 3'd4;
  localparam logic [2:0] ADR_BBDAT = 3'd5;
  localparam logic [2:0] ADR_BBOE  = 3'd6;

  localparam int CFG_SEL_BIT  = 0;
  localparam int CFG_POLL_BIT = 1;
  localparam int CFG_BB_BIT   = 2;
  localparam int CFG_PREG_LSB = 3;
  localparam int CFG_PPHY_LSB = 10;

  localparam int DONE_BIT = 16;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  typedef struct packed {
    logic [1:0]  start;
    logic [1:0]  opc;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  ta;
    logic [15:0] data;
  } mgmt_frame_t;

  function automatic mgmt_frame_t poll_frame(input logic [4:0] phy, input logic [4:0] regad);
    mgmt_frame_t f;
    f.start = START_PAT;
    f.opc   = OPC_READ;
    f.phy   = phy;
    f.regad = regad;
    f.ta    = 2'b00;
    f.data  = '0;
    return f;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(DIV - 1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter import mdio_pkg::*; #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_frame_t word,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdi,
  output logic        busy,
  output logic        done,
  output logic        mdo,
  output logic        oe,
  output logic [15:0] rdata
);
  localparam int TOTAL = PRE_LEN + FRAME_W;
  localparam int BW    = $clog2(TOTAL);

  logic [BW-1:0]        bidx;
  logic [BW-1:0]        rem;
  logic [4:0]           fpos;
  logic [FRAME_W-1:0]   word_q;
  logic                 in_pre;
  logic                 is_rd;

  assign rem    = BW'(TOTAL - 1) - bidx;
  assign fpos   = rem[4:0];
  assign in_pre = bidx < BW'(PRE_LEN);
  assign is_rd  = word_q[29:28] == OPC_READ;

  always_comb begin
    mdo = 1'b1;
    oe  = 1'b1;
    if (!in_pre) begin
      if (fpos >= 5'd18) begin
        mdo = word_q[fpos];
      end else if (is_rd) begin
        mdo = 1'b0;
        oe  = 1'b0;
      end else if (fpos >= 5'd16) begin
        mdo = (fpos == 5'd17);
      end else begin
        mdo = word_q[fpos];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      bidx   <= '0;
      word_q <= '0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        bidx   <= '0;
        word_q <= word;
        rdata  <= '0;
      end else if (busy) begin
        if (rise && is_rd && !in_pre && fpos < 5'd16)
          rdata <= {rdata[14:0], mdi};
        if (fall) begin
          if (bidx == BW'(TOTAL - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end
    end
  end

  // R2
  line_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(fall) |-> $stable(mdo) && $stable(oe));

  // R4
  release_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $fell(oe) |-> is_rd);
endmodule

// File: rtl/mdio_poll_unit.sv
module mdio_poll_unit #(
  parameter int GAP = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_en,
  input  logic        eng_idle,
  input  logic        done,
  input  logic [15:0] rdata,
  input  logic        clr,
  output logic        req,
  output logic [15:0] last,
  output logic [15:0] chg
);
  localparam int GW = $clog2(GAP + 1) > 0 ? $clog2(GAP + 1) : 1;

  logic [GW-1:0] gcnt;
  logic          inflight;
  logic          base_ok;

  assign req = poll_en && !inflight && eng_idle && (gcnt == GW'(GAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcnt     <= '0;
      inflight <= 1'b0;
      base_ok  <= 1'b0;
      last     <= '0;
      chg      <= '0;
    end else begin
      if (!poll_en) begin
        gcnt    <= '0;
        base_ok <= 1'b0;
      end else if (req) begin
        gcnt     <= '0;
        inflight <= 1'b1;
      end else if (!inflight && gcnt != GW'(GAP)) begin
        gcnt <= gcnt + 1'b1;
      end
      if (done) begin
        inflight <= 1'b0;
        last     <= rdata;
        base_ok  <= poll_en;
        chg      <= (clr ? 16'h0 : chg) | (base_ok ? (last ^ rdata) : 16'h0);
      end else if (clr) begin
        chg <= '0;
      end
    end
  end

  // R11
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !done |=> chg == 16'h0);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl import mdio_pkg::*; #(
  parameter int CLK_DIV      = 4,
  parameter int POLL_GAP     = 64,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic [1:0]  mdc,
  output logic [1:0]  mdio_out,
  output logic [1:0]  mdio_oe,
  input  logic [1:0]  mdio_in
);
  localparam int NPORT = 2;

  logic        cfg_sel, cfg_poll, cfg_bb;
  logic [4:0]  cfg_preg, cfg_pphy;
  logic [15:0] mask_q;
  logic        bb_clk_q, bb_dat_q, bb_oe_q;
  logic [31:0] frame_q;
  logic        sel_q, owner_poll;

  logic        eng_busy, eng_done, eng_mdc, eng_mdo, eng_oe, tk_rise, tk_fall;
  logic [15:0] eng_rdata;
  logic        poll_req, host_go, eng_start, stat_clr, poll_en;
  logic [15:0] p_last, p_chg;
  mgmt_frame_t start_word;

  assign poll_en   = cfg_poll && !cfg_bb;
  assign host_go   = wr_en && (wr_addr == ADR_FRAME) && !eng_busy && !cfg_bb && !cfg_poll;
  assign eng_start = host_go || poll_req;
  assign start_word = host_go ? mgmt_frame_t'(wr_data) : poll_frame(cfg_pphy, cfg_preg);
  assign stat_clr  = rd_en && (rd_addr == ADR_PSTAT);
  assign irq       = |(p_chg & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sel    <= 1'b0;
      cfg_poll   <= 1'b0;
      cfg_bb     <= 1'b0;
      cfg_preg   <= '0;
      cfg_pphy   <= '0;
      mask_q     <= 16'hFFFF;
      bb_clk_q   <= 1'b0;
      bb_dat_q   <= 1'b0;
      bb_oe_q    <= 1'b0;
      frame_q    <= '0;
      sel_q      <= 1'b0;
      owner_poll <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADR_CFG: begin
            cfg_sel  <= wr_data[CFG_SEL_BIT];
            cfg_poll <= wr_data[CFG_POLL_BIT];
            cfg_bb   <= wr_data[CFG_BB_BIT];
            cfg_preg <= wr_data[CFG_PREG_LSB +: 5];
            cfg_pphy <= wr_data[CFG_PPHY_LSB +: 5];
          end
          ADR_PMASK: mask_q   <= wr_data[15:0];
          ADR_BBCLK: bb_clk_q <= wr_data[0];
          ADR_BBDAT: bb_dat_q <= wr_data[0];
          ADR_BBOE:  bb_oe_q  <= wr_data[0];
          default: ;
        endcase
      end
      if (host_go) begin
        frame_q           <= wr_data;
        frame_q[DONE_BIT] <= 1'b0;
      end else if (eng_done && !owner_poll) begin
        frame_q[DONE_BIT] <= 1'b1;
        if (frame_q[29:28] == OPC_READ) frame_q[15:0] <= eng_rdata;
      end
      if (eng_start) begin
        sel_q      <= cfg_sel;
        owner_poll <= poll_req;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CFG: begin
        rd_data[CFG_SEL_BIT]       = cfg_sel;
        rd_data[CFG_POLL_BIT]      = cfg_poll;
        rd_data[CFG_BB_BIT]        = cfg_bb;
        rd_data[CFG_PREG_LSB +: 5] = cfg_preg;
        rd_data[CFG_PPHY_LSB +: 5] = cfg_pphy;
      end
      ADR_FRAME: rd_data = frame_q;
      ADR_PSTAT: rd_data = {p_last, p_chg};
      ADR_PMASK: rd_data = {16'h0, mask_q};
      ADR_BBCLK: rd_data = {31'h0, bb_clk_q};
      ADR_BBDAT: rd_data = {31'h0, bb_dat_q};
      ADR_BBOE:  rd_data = {31'h0, bb_oe_q};
      default:   rd_data = '0;
    endcase
  end

  mdio_clk_div #(.DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(eng_busy),
    .mdc(eng_mdc), .rise(tk_rise), .fall(tk_fall)
  );

  mdio_frame_shifter #(.PRE_LEN(PREAMBLE_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .word(start_word),
    .rise(tk_rise), .fall(tk_fall), .mdi(mdio_in[sel_q]),
    .busy(eng_busy), .done(eng_done), .mdo(eng_mdo), .oe(eng_oe), .rdata(eng_rdata)
  );

  mdio_poll_unit #(.GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .eng_idle(!eng_busy),
    .done(eng_done && owner_poll), .rdata(eng_rdata), .clr(stat_clr),
    .req(poll_req), .last(p_last), .chg(p_chg)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      mdc[p]      = 1'b0;
      mdio_out[p] = 1'b0;
      mdio_oe[p]  = 1'b0;
      if (cfg_bb) begin
        if (cfg_sel == 1'(p)) begin
          mdc[p]      = bb_clk_q;
          mdio_out[p] = bb_dat_q;
          mdio_oe[p]  = bb_oe_q;
        end
      end else if (eng_busy && sel_q == 1'(p)) begin
        mdc[p]      = eng_mdc;
        mdio_out[p] = eng_mdo;
        mdio_oe[p]  = eng_oe;
      end
    end
  end

  // R5
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy && wr_en && wr_addr == ADR_FRAME |=> $stable(frame_q));

  // R8
  bb_other_port_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bb |-> !mdc[!cfg_sel] && !mdio_oe[!cfg_sel]);
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  import mdio_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int GAP = 64;
  localparam int PRE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq;
  logic [1:0] mdc, mdio_out, mdio_oe;
  logic [1:0] phy_in = 2'b11;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV), .POLL_GAP(GAP), .PREAMBLE_LEN(PRE)) i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(phy_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  ra;
    logic [15:0] data;
  } xact_t;
  xact_t sb_q[$];
  xact_t cur;

  logic [15:0] phy_mem [32];
  int  tb_port = 0;
  bit  sb_on = 1'b1;
  logic [4:0] poll_phy = '0, poll_reg = '0;

  int ones = 0, st = 0, cnt = 0, rcnt = 0, fcnt = 0;
  int last_pre = 0, cyc = 0, last_rise = 0, period = 0;
  int rd_oe_viol = 0, other_edges = 0, poll_seen = 0, poll_bad = 0;
  logic [13:0] hdr = '0;
  logic [17:0] wd = '0;
  logic [4:0]  cur_ra = '0;
  logic pm = 1'b0, pother = 1'b0;

  // Monitor: models the PHY on the selected port and pops the scoreboard.
  always @(negedge clk) begin
    logic m, o, e, mo;
    cyc++;
    m  = mdc[tb_port];
    o  = mdio_out[tb_port];
    e  = mdio_oe[tb_port];
    mo = mdc[1 - tb_port];
    if (mo != pother) other_edges++;
    pother = mo;
    if (m && !pm) begin
      period = cyc - last_rise;
      last_rise = cyc;
      case (st)
        0: if (e) begin
             if (o) ones++;
             else begin
               if (ones >= PRE) begin
                 last_pre = ones; st = 1; hdr = '0; cnt = 1;
               end
               ones = 0;
             end
           end
        1: begin
             hdr = {hdr[12:0], o};
             cnt++;
             if (cnt == 14) begin
               cur_ra = hdr[4:0];
               if (sb_on) begin
                 if (sb_q.size() == 0) begin
                   chk(0, "R5", "unexpected frame on line", {18'h0, hdr}, 32'h0);
                   cur = '{op: hdr[11:10], phy: hdr[9:5], ra: hdr[4:0], data: 16'h0};
                 end else begin
                   cur = sb_q.pop_front();
                   chk({hdr[13:12], hdr[11:10], hdr[9:5], hdr[4:0]} == {START_PAT, cur.op, cur.phy, cur.ra},
                       "R3", "frame header bits", {18'h0, hdr}, {18'h0, START_PAT, cur.op, cur.phy, cur.ra});
                 end
               end else begin
                 poll_seen++;
                 if (hdr != {START_PAT, OPC_READ, poll_phy, poll_reg}) poll_bad++;
               end
               if (hdr[11:10] == OPC_READ) begin st = 2; rcnt = 0; fcnt = 0; end
               else begin st = 3; cnt = 0; wd = '0; end
             end
           end
        2: begin
             rcnt++;
             if (e) rd_oe_viol++;
             if (rcnt == 18) begin st = 0; phy_in[tb_port] = 1'b1; end
           end
        3: begin
             wd = {wd[16:0], o};
             cnt++;
             if (cnt == 18) begin
               chk(wd[17:16] == 2'b10, "R3", "write turnaround", {30'h0, wd[17:16]}, 32'h2);
               if (sb_on) chk(wd[15:0] == cur.data, "R3", "write data", {16'h0, wd[15:0]}, {16'h0, cur.data});
               phy_mem[cur_ra] = wd[15:0];
               st = 0;
             end
           end
        default: st = 0;
      endcase
    end
    if (!m && pm && st == 2) begin
      fcnt++;
      if (fcnt == 1) phy_in[tb_port] = 1'b1;
      else if (fcnt == 2) phy_in[tb_port] = 1'b0;
      else if (fcnt <= 18) phy_in[tb_port] = phy_mem[cur_ra][18 - fcnt];
    end
    pm = m;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input bit clr, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a; rd_en = clr;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] d);
    for (int i = 0; i < 400; i++) begin
      rd(ADR_FRAME, 1'b0, d);
      if (d[DONE_BIT]) break;
      repeat (8) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] mkword(input logic [1:0] op, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] data);
    return {START_PAT, op, phy, ra, 2'b10, data};
  endfunction

  task automatic host_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] data, output logic [31:0] fr);
    sb_q.push_back('{op: op, phy: phy, ra: ra, data: data});
    wr(ADR_FRAME, mkword(op, phy, ra, data));
    wait_done(fr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "ALL", "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, w;
    int snap;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;
    phy_mem[7] = 16'h1E2D;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(ADR_CFG, 0, d);   chk(d == 0, "R1", "config after reset", d, 0);
    rd(ADR_FRAME, 0, d); chk(d == 0, "R1", "frame after reset", d, 0);
    rd(ADR_PSTAT, 0, d); chk(d == 0, "R1", "poll status after reset", d, 0);
    rd(ADR_PMASK, 0, d); chk(d == 32'h0000FFFF, "R1", "mask after reset", d, 32'h0000FFFF);
    chk({irq, mdc, mdio_oe, mdio_out} == 0, "R1", "pins after reset",
        {25'h0, irq, mdc, mdio_oe, mdio_out}, 0);

    // R3/R2 host write on port 0
    host_frame(OPC_WRITE, 5'd5, 5'd3, 16'hA5C3, d);
    w = mkword(OPC_WRITE, 5'd5, 5'd3, 16'hA5C3);
    chk(d == (w | 32'h10000), "R4", "frame reg after write done", d, w | 32'h10000);
    chk(last_pre == PRE, "R2", "preamble length", last_pre, PRE);
    chk(period == 2 * DIV, "R7", "management clock period", period, 2 * DIV);

    // R4 host reads, two data patterns
    host_frame(OPC_READ, 5'd5, 5'd3, 16'h0, d);
    chk(d[16:0] == {1'b1, 16'hA5C3}, "R4", "read data reg3", d, {15'h0, 1'b1, 16'hA5C3});
    host_frame(OPC_READ, 5'd5, 5'd7, 16'h0, d);
    chk(d[16:0] == {1'b1, 16'h1E2D}, "R4", "read data reg7", d, {15'h0, 1'b1, 16'h1E2D});
    chk(rd_oe_viol == 0, "R4", "line released in read turnaround", rd_oe_viol, 0);

    // R5 write while busy dropped
    w = mkword(OPC_WRITE, 5'd5, 5'd9, 16'h1111);
    sb_q.push_back('{op: OPC_WRITE, phy: 5'd5, ra: 5'd9, data: 16'h1111});
    wr(ADR_FRAME, w);
    repeat (20) @(negedge clk);
    rd(ADR_FRAME, 0, d);
    chk(d == w, "R4", "done bit low while running", d, w);
    wr(ADR_FRAME, mkword(OPC_WRITE, 5'd5, 5'd10, 16'h2222));
    wait_done(d);
    chk(d == (w | 32'h10000), "R5", "frame reg kept first word", d, w | 32'h10000);
    repeat (600) @(negedge clk);
    chk(phy_mem[10] == 16'h0, "R5", "dropped frame not sent", {16'h0, phy_mem[10]}, 0);

    // R6 port 1
    wr(ADR_CFG, 32'h1);
    tb_port = 1;
    other_edges = 0;
    host_frame(OPC_WRITE, 5'd2, 5'd4, 16'h0F0F, d);
    chk(other_edges == 0, "R6", "unselected port clock quiet", other_edges, 0);
    chk(phy_mem[4] == 16'h0F0F, "R6", "write reached port 1", {16'h0, phy_mem[4]}, 32'h0F0F);
    chk(sb_q.size() == 0, "R3", "scoreboard drained", sb_q.size(), 0);

    // R8 bit-bang
    wr(ADR_CFG, 32'h5);
    wr(ADR_BBCLK, 1); wr(ADR_BBDAT, 1); wr(ADR_BBOE, 1);
    @(negedge clk);
    chk({mdc, mdio_out, mdio_oe} == 6'b10_10_10, "R8", "bit-bang pins",
        {26'h0, mdc, mdio_out, mdio_oe}, 32'h2A);
    rd(ADR_FRAME, 0, w);
    wr(ADR_FRAME, mkword(OPC_WRITE, 5'd1, 5'd1, 16'hBEEF));
    repeat (4) @(negedge clk);
    rd(ADR_FRAME, 0, d);
    chk(d == w, "R8", "frame write dropped in bit-bang", d, w);
    wr(ADR_BBDAT, 0);
    @(negedge clk);
    chk(mdio_out[1] == 1'b0, "R8", "bit-bang data follows", {31'h0, mdio_out[1]}, 0);
    wr(ADR_BBCLK, 0); wr(ADR_BBOE, 0);
    wr(ADR_CFG, 32'h1);

    // R9 polling baseline
    sb_on = 1'b0;
    poll_phy = 5'd2; poll_reg = 5'd6;
    phy_mem[6] = 16'h8001;
    wr(ADR_CFG, 32'h1 | 32'h2 | (32'd6 << 3) | (32'd2 << 10));
    repeat (2000) @(negedge clk);
    rd(ADR_PSTAT, 0, d);
    chk(d == 32'h80010000, "R9", "poll baseline status", d, 32'h80010000);
    chk(irq == 1'b0, "R9", "no irq on baseline", {31'h0, irq}, 0);
    chk(poll_seen >= 2 && poll_bad == 0, "R9", "polls target configured reg", poll_bad, 0);

    // R10 unmasked change
    wr(ADR_PMASK, 32'h0020);
    phy_mem[6] = 16'h8009;
    repeat (1300) @(negedge clk);
    chk(irq == 1'b1, "R10", "irq on unmasked change", {31'h0, irq}, 1);
    rd(ADR_PSTAT, 1, d);
    chk(d == 32'h80090008, "R10", "change bits", d, 32'h80090008);
    rd(ADR_PSTAT, 0, d);
    chk(d[15:0] == 16'h0 && irq == 1'b0, "R11", "clear on read", {irq, d[30:0]}, 32'h0);

    // R10 masked change
    phy_mem[6] = 16'h8029;
    repeat (1300) @(negedge clk);
    rd(ADR_PSTAT, 0, d);
    chk(d == 32'h80290020, "R10", "masked change recorded", d, 32'h80290020);
    chk(irq == 1'b0, "R10", "masked change no irq", {31'h0, irq}, 0);

    // R9 stop polling
    wr(ADR_CFG, 32'h1);
    repeat (1000) @(negedge clk);
    snap = poll_seen;
    repeat (1500) @(negedge clk);
    chk(poll_seen == snap, "R9", "polling stops", poll_seen, snap);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule